// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block executes the two floating-point compare operations of a processor's FPU: equal and greater-than. It works on either single-precision (32-bit) or double-precision (64-bit) operands. A precision-mode input chooses the format for every compare. The unit decodes a 16-bit instruction word that arrives with a valid strobe. It presents the two register-file read indices taken from that word. It then accepts the operand values read from those registers: 32-bit registers, where an even/odd pair forms a 64-bit double.

One cycle after an accepted compare, the unit outputs the following:

- the new T flag;
- the invalid-operation cause bit, which is rewritten by every compare;
- a sticky invalid flag;
- an exception request;
- the incremented program counter.

The two compare kinds handle NaNs differently. Equality raises invalid only for a signaling NaN. Greater-than raises invalid for any unordered pair. Positive and negative zero compare equal. Ordering follows sign-magnitude rules, so the magnitude test is reversed when both operands are negative.

Top module: `fcmp_unit`

## Requirements
- R1: A word with bits [15:12]=4'b1111 and bits [3:1]=3'b010 is a compare; bit 0 selects equal (0) or greater-than (1). `rn_o` is bits [11:8] and `rm_o` is bits [7:4]. Any other word with the valid strobe set is ignored: no `done_o`, no `ill_o`, and T, cause and flag are unchanged.
- R2: With `pr_i`=0, only bits [31:0] of each operand take part. Equal sets T to 1 exactly when the two singles are equal, and to 0 otherwise.
- R3: Greater-than sets T to 1 exactly when operand n exceeds operand m, and to 0 otherwise. This holds for operands of either sign.
- R4: With `pr_i`=1, all 64 bits of each operand are compared as doubles.
- R5: With `pr_i`=1, a compare word whose n or m field has bit 0 set pulses `ill_o` one cycle later. It produces no `done_o` and leaves T, cause and flag unchanged.
- R6: +0 and -0 compare equal, and neither is greater than the other.
- R7: For equal, a quiet NaN operand (most significant fraction bit 1) gives T=0 with no invalid. A signaling NaN operand (NaN with most significant fraction bit 0) raises invalid.
- R8: For greater-than, any NaN operand, quiet or signaling, raises invalid.
- R9: The cause bit is rewritten on every compare: 1 if that compare raised invalid, 0 if not. The flag is set by any invalid and is cleared only by reset.
- R10: If invalid is raised and `inv_en_i`=1, `exc_o` pulses together with `done_o` and T keeps its value. If invalid is raised and `inv_en_i`=0, T becomes 0 and `exc_o` stays low.
- R11: Every executed compare sets `pc_o` to `pc_i`+2. The value appears together with `done_o`.
- R12: After reset, `t_o`, `cause_inv_o`, `flag_inv_o`, `done_o`, `exc_o` and `ill_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word valid |
| insn_i | input | 16 | Instruction word |
| pr_i | input | 1 | Precision mode: 0 single, 1 double |
| inv_en_i | input | 1 | Invalid-operation trap enable |
| pc_i | input | 32 | Address of the instruction |
| opn_i | input | 64 | Operand n; single uses bits [31:0] |
| opm_i | input | 64 | Operand m; single uses bits [31:0] |
| rn_o | output | 4 | Register index n read from the word |
| rm_o | output | 4 | Register index m read from the word |
| done_o | output | 1 | A compare completed this cycle |
| ill_o | output | 1 | Odd register field in double mode |
| t_o | output | 1 | T flag |
| cause_inv_o | output | 1 | Invalid cause of the last compare |
| flag_inv_o | output | 1 | Sticky invalid flag |
| exc_o | output | 1 | Exception request |
| pc_o | output | 32 | Next program counter |

## Verification
Ordered pairs are applied in both directions, with equal and unequal operands, mixed signs and two negatives. This separates a plain magnitude comparison from correct sign-magnitude ordering. Double operands are chosen with identical low words but different high words, which exposes any use of single width in double mode. Pairs of zeros, quiet NaNs and signaling NaNs are each run through both compare kinds, with the trap enable on and off. This separates the equal and greater-than invalid rules from each other and distinguishes the trapped and untrapped updates of T. Foreign words and odd double fields are followed by reads of T, cause and flag to show that nothing moved.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int INSN_W = 16;
  localparam int REG_AW = 4;
  localparam int OP_W   = 64;
  localparam int SGL_W  = 32;
  localparam int SGL_E  = 8;
  localparam int DBL_W  = 64;
  localparam int DBL_E  = 11;
  localparam logic [3:0] MAJOR_OP = 4'hF;
  localparam logic [2:0] MINOR_OP = 3'b010;

  typedef enum logic {CMP_EQ = 1'b0, CMP_GT = 1'b1} cmp_kind_e;

  typedef struct packed {
    logic eq;
    logic gt;
    logic unord;
    logic snan;
  } cmp_res_t;
endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  input  logic              pr_i,
  output logic              hit_o,
  output logic              ill_o,
  output cmp_kind_e         kind_o,
  output logic [REG_AW-1:0] rn_o,
  output logic [REG_AW-1:0] rm_o
);
  assign rn_o   = insn_i[11:8];
  assign rm_o   = insn_i[7:4];
  assign hit_o  = (insn_i[15:12] == MAJOR_OP) && (insn_i[3:1] == MINOR_OP);
  assign kind_o = cmp_kind_e'(insn_i[0]);
  // double pairs must be addressed by the even register
  assign ill_o  = hit_o && pr_i && (rn_o[0] || rm_o[0]);
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int W  = 32,
  parameter int EW = 8
) (
  input  logic [W-1:0] a_i,   // operand n
  input  logic [W-1:0] b_i,   // operand m
  output cmp_res_t     res_o
);
  localparam int FW = W - 1 - EW;

  logic a_nan, b_nan, a_snan, b_snan, a_zero, b_zero, a_s, b_s;
  logic [W-2:0] a_mag, b_mag;
  logic mag_gt, mag_lt, both_zero, ord_gt;

  assign a_s    = a_i[W-1];
  assign b_s    = b_i[W-1];
  assign a_mag  = a_i[W-2:0];
  assign b_mag  = b_i[W-2:0];
  assign a_nan  = (&a_i[W-2:FW]) && (|a_i[FW-1:0]);
  assign b_nan  = (&b_i[W-2:FW]) && (|b_i[FW-1:0]);
  assign a_snan = a_nan && !a_i[FW-1];
  assign b_snan = b_nan && !b_i[FW-1];
  assign a_zero = (a_mag == '0);
  assign b_zero = (b_mag == '0);
  assign both_zero = a_zero && b_zero;
  assign mag_gt = a_mag > b_mag;
  assign mag_lt = a_mag < b_mag;

  always_comb begin
    if (a_s != b_s) ord_gt = !a_s;
    else if (a_s)   ord_gt = mag_lt;  // both negative: order reversed
    else            ord_gt = mag_gt;
  end

  assign res_o.unord = a_nan || b_nan;
  assign res_o.snan  = a_snan || b_snan;
  assign res_o.eq    = !res_o.unord && (both_zero || (a_i == b_i));
  assign res_o.gt    = !res_o.unord && !both_zero && ord_gt;
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              pr_i,
  input  logic              inv_en_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [OP_W-1:0]   opn_i,
  input  logic [OP_W-1:0]   opm_i,
  output logic [REG_AW-1:0] rn_o,
  output logic [REG_AW-1:0] rm_o,
  output logic              done_o,
  output logic              ill_o,
  output logic              t_o,
  output logic              cause_inv_o,
  output logic              flag_inv_o,
  output logic              exc_o,
  output logic [PC_W-1:0]   pc_o
);
  localparam int NFMT = 2;

  logic      hit, ill_d, exec, invalid, trap, t_new;
  cmp_kind_e kind;
  cmp_res_t  res_fmt [NFMT];
  cmp_res_t  res;

  fcmp_decode u_dec (
    .insn_i (insn_i),
    .pr_i   (pr_i),
    .hit_o  (hit),
    .ill_o  (ill_d),
    .kind_o (kind),
    .rn_o   (rn_o),
    .rm_o   (rm_o)
  );

  for (genvar f = 0; f < NFMT; f++) begin : g_fmt
    localparam int FW_W = (f == 0) ? SGL_W : DBL_W;
    localparam int FW_E = (f == 0) ? SGL_E : DBL_E;
    fcmp_order #(.W(FW_W), .EW(FW_E)) u_ord (
      .a_i   (opn_i[FW_W-1:0]),
      .b_i   (opm_i[FW_W-1:0]),
      .res_o (res_fmt[f])
    );
  end

  assign res     = pr_i ? res_fmt[1] : res_fmt[0];
  assign exec    = valid_i && hit && !ill_d;
  assign invalid = (kind == CMP_GT) ? res.unord : res.snan;
  assign trap    = invalid && inv_en_i;
  assign t_new   = invalid ? 1'b0 : ((kind == CMP_GT) ? res.gt : res.eq);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      ill_o       <= 1'b0;
      t_o         <= 1'b0;
      cause_inv_o <= 1'b0;
      flag_inv_o  <= 1'b0;
      exc_o       <= 1'b0;
      pc_o        <= '0;
    end else begin
      done_o <= exec;
      ill_o  <= valid_i && ill_d;
      exc_o  <= exec && trap;
      if (exec) begin
        cause_inv_o <= invalid;       // cause rewritten every compare
        if (invalid) flag_inv_o <= 1'b1;
        if (!trap)   t_o <= t_new;
        pc_o <= pc_i + PC_W'(2);
      end
    end
  end
endmodule

// File: rtl/fcmp_unit_sva.sv
module fcmp_unit_sva #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [15:0]     insn_i,
  input logic [PC_W-1:0] pc_i,
  input logic            done_o,
  input logic            ill_o,
  input logic            t_o,
  input logic            cause_inv_o,
  input logic            flag_inv_o,
  input logic            exc_o,
  input logic [PC_W-1:0] pc_o
);
  logic foreign;
  assign foreign = valid_i && ((insn_i[15:12] != 4'hF) || (insn_i[3:1] != 3'b010));

  p_foreign_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    foreign |=> !done_o && !ill_o);
  p_ill_no_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ill_o && done_o));
  p_cause_sets_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cause_inv_o) |-> flag_inv_o);
  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_inv_o |=> flag_inv_o);
  p_exc_with_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (done_o && cause_inv_o));
  p_exc_keeps_t_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $stable(t_o));
  p_untrapped_t0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cause_inv_o && !exc_o) |-> !t_o);
  p_pc_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pc_o == $past(pc_i) + PC_W'(2)));
endmodule

bind fcmp_unit fcmp_unit_sva #(.PC_W(PC_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .insn_i      (insn_i),
  .pc_i        (pc_i),
  .done_o      (done_o),
  .ill_o       (ill_o),
  .t_o         (t_o),
  .cause_inv_o (cause_inv_o),
  .flag_inv_o  (flag_inv_o),
  .exc_o       (exc_o),
  .pc_o        (pc_o)
);

// File: tb/fcmp_unit_tb.sv
module fcmp_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] insn_i = '0;
  logic        pr_i = 1'b0;
  logic        inv_en_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [63:0] opn_i = '0;
  logic [63:0] opm_i = '0;
  logic [3:0]  rn_o, rm_o;
  logic        done_o, ill_o, t_o, cause_inv_o, flag_inv_o, exc_o;
  logic [31:0] pc_o;

  int errors = 0;
  int checks = 0;
  logic exp_flag = 1'b0;
  logic exp_t = 1'b0;

  localparam logic [15:0] EQ24 = 16'hF244;
  localparam logic [15:0] GT24 = 16'hF245;
  localparam logic [63:0] S_P1 = 64'h3F800000, S_P2 = 64'h40000000;
  localparam logic [63:0] S_N1 = 64'hBF800000, S_N2 = 64'hC0000000;
  localparam logic [63:0] S_PZ = 64'h0, S_NZ = 64'h80000000;
  localparam logic [63:0] S_QN = 64'h7FC00000, S_SN = 64'h7F800001;
  localparam logic [63:0] D_P1 = 64'h3FF0000000000000, D_P2 = 64'h4000000000000000;
  localparam logic [63:0] D_N2 = 64'hC000000000000000;
  localparam logic [63:0] D_QN = 64'h7FF8000000000000, D_SN = 64'h7FF0000000000001;

  always #2.5 clk_i = ~clk_i;

  fcmp_unit u_dut (.*);

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one strobed word, outputs sampled one cycle later at negedge
  task automatic issue(input logic [15:0] w, input logic pr, input logic en,
                       input logic [63:0] n, input logic [63:0] m);
    @(negedge clk_i);
    valid_i = 1'b1; insn_i = w; pr_i = pr; inv_en_i = en;
    opn_i = n; opm_i = m; pc_i = pc_i + 32'h10;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic cmp(input string req, input logic [15:0] w, input logic pr,
                     input logic en, input logic [63:0] n, input logic [63:0] m,
                     input logic t_res, input logic inv);
    issue(w, pr, en, n, m);
    if (inv) exp_flag = 1'b1;
    if (!(inv && en)) exp_t = inv ? 1'b0 : t_res;
    chk({req, " done"}, 32'(done_o), 32'd1);
    chk({req, " t"}, 32'(t_o), 32'(exp_t));
    chk({req, " cause"}, 32'(cause_inv_o), 32'(inv));
    chk({req, " flag"}, 32'(flag_inv_o), 32'(exp_flag));
    chk({req, " exc"}, 32'(exc_o), 32'(inv && en));
    chk({req, " pc"}, pc_o, pc_i + 32'd2);
  endtask

  task automatic t_reset;
    chk("R12 t", 32'(t_o), 0);
    chk("R12 cause", 32'(cause_inv_o), 0);
    chk("R12 flag", 32'(flag_inv_o), 0);
    chk("R12 done", 32'(done_o), 0);
    chk("R12 exc", 32'(exc_o), 0);
    chk("R12 ill", 32'(ill_o), 0);
  endtask

  task automatic t_single_eq;
    @(negedge clk_i); insn_i = 16'hF7A4;
    #1 chk("R1 rn", 32'(rn_o), 32'h7);
    chk("R1 rm", 32'(rm_o), 32'hA);
    cmp("R2 eq same", EQ24, 0, 0, S_P1, S_P1, 1, 0);
    cmp("R2 eq diff", EQ24, 0, 0, S_P1, S_P2, 0, 0);
    cmp("R2 high bits ignored", EQ24, 0, 0, {32'hDEAD0000, S_P2[31:0]}, S_P2, 1, 0);
  endtask

  task automatic t_single_gt;
    cmp("R3 gt pos", GT24, 0, 0, S_P2, S_P1, 1, 0);
    cmp("R3 gt pos rev", GT24, 0, 0, S_P1, S_P2, 0, 0);
    cmp("R3 gt neg", GT24, 0, 0, S_N1, S_N2, 1, 0);
    cmp("R3 gt neg rev", GT24, 0, 0, S_N2, S_N1, 0, 0);
    cmp("R3 gt mixed", GT24, 0, 0, S_N1, S_P1, 0, 0);
    cmp("R3 gt equal", GT24, 0, 0, S_P1, S_P1, 0, 0);
  endtask

  task automatic t_double;
    cmp("R4 eq low same", EQ24, 1, 0, D_P2, D_P1, 0, 0);
    cmp("R4 gt", GT24, 1, 0, D_P2, D_P1, 1, 0);
    cmp("R4 gt neg", GT24, 1, 0, D_N2, D_P1, 0, 0);
    cmp("R4 eq", EQ24, 1, 0, D_P1, D_P1, 1, 0);
  endtask

  task automatic t_zero;
    cmp("R6 eq zeros", EQ24, 0, 0, S_NZ, S_PZ, 1, 0);
    cmp("R6 gt +0 -0", GT24, 0, 0, S_PZ, S_NZ, 0, 0);
    cmp("R6 gt -0 +0", GT24, 0, 0, S_NZ, S_PZ, 0, 0);
  endtask

  task automatic t_nan;
    cmp("R3 set t", GT24, 0, 0, S_P2, S_P1, 1, 0);
    cmp("R7 eq qnan", EQ24, 0, 0, S_QN, S_QN, 0, 0);
    chk("R7 flag untouched", 32'(flag_inv_o), 0);
    cmp("R3 set t", GT24, 0, 0, S_P2, S_P1, 1, 0);
    cmp("R10 eq snan trapped", EQ24, 0, 1, S_SN, S_P1, 0, 1);
    cmp("R9 cause cleared", EQ24, 0, 1, S_P1, S_P1, 1, 0);
    cmp("R10 eq snan untrapped", EQ24, 0, 0, S_P1, S_SN, 0, 1);
    cmp("R3 set t", GT24, 0, 0, S_P2, S_P1, 1, 0);
    cmp("R8 gt qnan trapped", GT24, 0, 1, S_QN, S_P1, 0, 1);
    cmp("R8 gt qnan untrapped", GT24, 0, 0, S_P1, S_QN, 0, 1);
    cmp("R8 gt snan dbl", GT24, 1, 0, D_SN, D_P1, 0, 1);
    cmp("R7 eq qnan dbl", EQ24, 1, 0, D_QN, D_P1, 0, 0);
    chk("R9 flag sticky", 32'(flag_inv_o), 1);
  endtask

  task automatic t_ignored;
    cmp("R3 set t", GT24, 0, 0, S_P2, S_P1, 1, 0);
    issue(16'hF246, 0, 0, S_P1, S_P1);
    chk("R1 foreign done", 32'(done_o), 0);
    chk("R1 foreign ill", 32'(ill_o), 0);
    chk("R1 foreign t", 32'(t_o), 1);
    issue(16'hE244, 0, 0, S_P1, S_P1);
    chk("R1 foreign2 done", 32'(done_o), 0);
    chk("R1 foreign2 t", 32'(t_o), 1);
    issue(16'hF344, 1, 0, D_P1, D_P1);
    chk("R5 odd n ill", 32'(ill_o), 1);
    chk("R5 odd n done", 32'(done_o), 0);
    chk("R5 odd n t", 32'(t_o), 1);
    issue(16'hF254, 1, 0, D_SN, D_P1);
    chk("R5 odd m ill", 32'(ill_o), 1);
    chk("R5 odd m cause", 32'(cause_inv_o), 0);
    chk("R5 odd m t", 32'(t_o), 1);
    issue(16'hF344, 0, 0, S_P1, S_P1);
    chk("R5 odd single ok", 32'(ill_o), 0);
    chk("R2 odd single t", 32'(t_o), 1);
  endtask

  initial begin
    #1 t_reset;
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_single_eq;
    t_single_gt;
    t_double;
    t_zero;
    t_ignored;
    t_nan;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule